// File: doc/BRIEF.md
# Readout Packet Word Formatter

The formatter turns a stream of per-frame readout events into the byte stream of a readout link. Each event is one of three kinds: the opening of a frame (with bits [10:3] of the bunch counter), one pixel hit record (region, encoder, pixel address and an optional 7-bit cluster map), or the close of a frame (with four readout flags). From these it builds variable-length prefix-coded words of 8, 16 and 24 bits and sends them byte by byte over a valid/ready output. A frame header is only emitted in front of the first hit. A frame that closes without hits collapses into one empty-frame word.

A separate busy status input is watched continuously. Each change of that status is reported as a one-byte busy word, placed at the first word boundary of the outgoing stream so that no multi-byte word is ever split. When nothing is pending, the link carries the idle filler byte. The close-of-frame flags pass through a priority override: a fatal condition or a data-overrun condition replaces them with fixed patterns.

Events are accepted one at a time and only while no bytes of an earlier event are still queued. Upstream logic that produces the hits supplies them with regions in ascending order within a frame.

Top module: `rdo_word_fmt`

## Requirements
- R1: From the first cycle after reset `out_valid` is high. The link shows 0xFF whenever no word byte and no busy word is due. A byte is consumed only in a cycle with `out_ready` high.
- R2: A frame that closes without any hit produces exactly one 16-bit word, {4'b1110, node_id, bunch[10:3]}, and no header or trailer.
- R3: The first hit of a frame is preceded by the 16-bit header {4'b1010, node_id, bunch[10:3]}. `node_id` is sampled when that hit is accepted and the bunch value when the frame opened.
- R4: A region byte {3'b110, region[4:0]} is emitted before a hit whose region differs from that of the previous hit in the frame, and always before the first hit of a frame. It is not repeated for consecutive hits in the same region.
- R5: A hit with `ev_long` low becomes {2'b01, encoder[3:0], addr[9:0]}. With `ev_long` high it becomes {2'b00, encoder, addr, 1'b0, map[6:0]}, where map bit 0 stands for the pixel right after addr and bit 6 for the seventh after it. Every multi-byte word leaves most significant byte first.
- R6: A frame closing after at least one hit yields the trailer byte {4'b1011, flags[3:0]}. From MSB to LSB the flags are busy-violation, flushed-incomplete, strobe-extended and busy-transition, and they pass through unchanged when no override applies.
- R7: With `fatal_in` high at frame close, the trailer flags become 4'b1110 whatever the other inputs are. Otherwise, with `overrun_in` high they become 4'b1100.
- R8: `busy_in` is registered once. A change of the registered value is reported by one byte, 0xF1 for busy or 0xF0 for not busy, at the first word boundary. With the link idle and `out_ready` high, that byte appears in the cycle after the one in which `busy_in` changed. A busy byte never falls between the bytes of one word, and successive busy bytes alternate.
- R9: When a busy report is due at a word boundary, it goes out before the next queued word.
- R10: The event kind is coded 0 = frame open, 1 = hit, 2 = frame close. Kind 3 is accepted but changes neither the output stream nor the frame state. `ev_ready` is high only while no bytes of an earlier event are queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | 4 | Identifier placed in header and empty-frame words |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event accepted in this cycle when `ev_valid` is high |
| ev_kind | input | 2 | 0 open, 1 hit, 2 close, 3 ignored |
| ev_bunch | input | 8 | Bunch counter bits [10:3] (frame open) |
| ev_region | input | 5 | Region index (hit) |
| ev_encoder | input | 4 | Encoder index within the region (hit) |
| ev_addr | input | 10 | Pixel address (hit) |
| ev_long | input | 1 | Hit carries a cluster map (hit) |
| ev_hitmap | input | 7 | Cluster map of the seven following pixels (hit) |
| ev_flags | input | 4 | Readout flags (frame close) |
| fatal_in | input | 1 | Fatal condition, forces flags 4'b1110 |
| overrun_in | input | 1 | Data-overrun mode, forces flags 4'b1100 |
| busy_in | input | 1 | Busy status to report |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the byte |
| out_byte | output | 8 | Output byte |

## Verification
A busy report and a multi-byte word compete for the same output slot. A change of `busy_in` can land while a header, data or empty-frame word is half sent, or while a queued word is waiting at a boundary. The bench toggles `busy_in` at random over hundreds of frames while `out_ready` stalls at random, so both cases occur often. A parser on the output knows from its own expected word list where every word begins. It accepts a busy byte only at such a boundary, requires busy bytes to alternate and end on the final status, and in a directed case requires the busy byte to go out ahead of an already queued header.

// File: rtl/rdo_fmt_pkg.sv
package rdo_fmt_pkg;

  localparam int BYTE_W  = 8;
  localparam int ID_W    = 4;
  localparam int BUNCH_W = 8;
  localparam int REG_W   = 5;
  localparam int ENC_W   = 4;
  localparam int ADDR_W  = 10;
  localparam int MAP_W   = 7;
  localparam int FLAG_W  = 4;
  // longest byte sequence one event can create: header + region + long data
  localparam int QUEUE_BYTES = 6;

  localparam logic [BYTE_W-1:0] IDLE_B     = 8'hFF;
  localparam logic [BYTE_W-1:0] BUSY_ON_B  = 8'hF1;
  localparam logic [BYTE_W-1:0] BUSY_OFF_B = 8'hF0;

  typedef enum logic [1:0] {
    EV_OPEN  = 2'd0,
    EV_HIT   = 2'd1,
    EV_CLOSE = 2'd2,
    EV_NONE  = 2'd3
  } ev_kind_e;

  function automatic logic [15:0] hdr_word(logic [ID_W-1:0] id, logic [BUNCH_W-1:0] bc);
    return {4'b1010, id, bc};
  endfunction

  function automatic logic [15:0] empty_word(logic [ID_W-1:0] id, logic [BUNCH_W-1:0] bc);
    return {4'b1110, id, bc};
  endfunction

  function automatic logic [7:0] region_byte(logic [REG_W-1:0] r);
    return {3'b110, r};
  endfunction

  function automatic logic [15:0] short_word(logic [ENC_W-1:0] e, logic [ADDR_W-1:0] a);
    return {2'b01, e, a};
  endfunction

  function automatic logic [23:0] long_word(logic [ENC_W-1:0] e, logic [ADDR_W-1:0] a,
                                            logic [MAP_W-1:0] m);
    return {2'b00, e, a, 1'b0, m};
  endfunction

  // fatal outranks overrun, which outranks the event's own flags
  function automatic logic [FLAG_W-1:0] resolve_flags(logic fatal, logic ovr,
                                                      logic [FLAG_W-1:0] f);
    if (fatal) return 4'b1110;
    if (ovr)   return 4'b1100;
    return f;
  endfunction

  function automatic logic [7:0] trailer_byte(logic [FLAG_W-1:0] f);
    return {4'b1011, f};
  endfunction

endpackage

// File: rtl/rdo_busy_tracker.sv
module rdo_busy_tracker
  import rdo_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_in,
  input  logic              take,
  output logic              pend,
  output logic [BYTE_W-1:0] code
);

  logic busy_q;    // registered status
  logic rep_q;     // last status put on the link

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rep_q  <= 1'b0;
    end else begin
      busy_q <= busy_in;
      if (take) rep_q <= busy_q;
    end
  end

  assign pend = (busy_q != rep_q);
  assign code = busy_q ? BUSY_ON_B : BUSY_OFF_B;

  // R8: an unreported change stays pending until sent or cancelled by the input
  assert_pend_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !take) |=> (pend || (busy_q != $past(busy_q))));

endmodule

// File: rtl/rdo_word_builder.sv
module rdo_word_builder
  import rdo_fmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ID_W-1:0]    node_id,
  input  logic               ev_valid,
  output logic               ev_ready,
  input  logic [1:0]         ev_kind,
  input  logic [BUNCH_W-1:0] ev_bunch,
  input  logic [REG_W-1:0]   ev_region,
  input  logic [ENC_W-1:0]   ev_encoder,
  input  logic [ADDR_W-1:0]  ev_addr,
  input  logic               ev_long,
  input  logic [MAP_W-1:0]   ev_hitmap,
  input  logic [FLAG_W-1:0]  ev_flags,
  input  logic               fatal_in,
  input  logic               overrun_in,
  input  logic               pop,
  output logic [BYTE_W-1:0]  head_byte,
  output logic               head_start,
  output logic               q_empty
);

  localparam int QB = QUEUE_BYTES;
  localparam int QW = QB * BYTE_W;
  localparam int CW = $clog2(QB + 1);

  logic [QW-1:0]      bufq, nb;
  logic [QB-1:0]      wsq, ns;      // word-start marks, MSB = head byte
  logic [CW-1:0]      cnt;
  int                 nlen;
  logic               hdr_pend, reg_valid;
  logic [REG_W-1:0]   cur_reg;
  logic [BUNCH_W-1:0] bunch_q;
  logic               ev_fire;
  ev_kind_e           kind;

  assign kind     = ev_kind_e'(ev_kind);
  assign ev_ready = (cnt == '0);
  assign ev_fire  = ev_valid && ev_ready;

  // assemble the bytes of one event, head byte in the top slot
  always_comb begin
    nb   = '1;
    ns   = '0;
    nlen = 0;
    if (ev_fire && kind == EV_HIT) begin
      if (hdr_pend) begin
        nb[QW-1-8*nlen -: 16] = hdr_word(node_id, bunch_q);
        ns[QB-1-nlen] = 1'b1;
        nlen += 2;
      end
      if (!reg_valid || ev_region != cur_reg) begin
        nb[QW-1-8*nlen -: 8] = region_byte(ev_region);
        ns[QB-1-nlen] = 1'b1;
        nlen += 1;
      end
      ns[QB-1-nlen] = 1'b1;
      if (ev_long) begin
        nb[QW-1-8*nlen -: 24] = long_word(ev_encoder, ev_addr, ev_hitmap);
        nlen += 3;
      end else begin
        nb[QW-1-8*nlen -: 16] = short_word(ev_encoder, ev_addr);
        nlen += 2;
      end
    end else if (ev_fire && kind == EV_CLOSE) begin
      ns[QB-1] = 1'b1;
      if (hdr_pend) begin
        nb[QW-1 -: 16] = empty_word(node_id, bunch_q);
        nlen = 2;
      end else begin
        nb[QW-1 -: 8] = trailer_byte(resolve_flags(fatal_in, overrun_in, ev_flags));
        nlen = 1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bufq      <= '1;
      wsq       <= '0;
      cnt       <= '0;
      hdr_pend  <= 1'b0;
      reg_valid <= 1'b0;
      cur_reg   <= '0;
      bunch_q   <= '0;
    end else if (ev_fire) begin
      bufq <= nb;
      wsq  <= ns;
      cnt  <= CW'(nlen);
      case (kind)
        EV_OPEN: begin
          hdr_pend  <= 1'b1;
          reg_valid <= 1'b0;
          bunch_q   <= ev_bunch;
        end
        EV_HIT: begin
          hdr_pend  <= 1'b0;
          reg_valid <= 1'b1;
          cur_reg   <= ev_region;
        end
        EV_CLOSE: begin
          hdr_pend  <= 1'b0;
          reg_valid <= 1'b0;
        end
        default: ;
      endcase
    end else if (pop) begin
      bufq <= {bufq[QW-BYTE_W-1:0], IDLE_B};
      wsq  <= {wsq[QB-2:0], 1'b0};
      cnt  <= cnt - 1'b1;
    end
  end

  assign head_byte  = bufq[QW-1 -: BYTE_W];
  assign head_start = wsq[QB-1];
  assign q_empty    = (cnt == '0);

  // R10: the queue never holds more than one event's bytes
  assert_queue_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(QB));

  // R1: each consumed byte shortens the queue by exactly one
  assert_pop_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (cnt == $past(cnt) - 1'b1));

  // R7: fatal at frame close forces the trailer pattern
  assert_fatal_trailer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && kind == EV_CLOSE && !hdr_pend && fatal_in) |=> (bufq[QW-1 -: 8] == 8'hBE));

endmodule

// File: rtl/rdo_out_select.sv
module rdo_out_select
  import rdo_fmt_pkg::*;
(
  input  logic              valid_q,
  input  logic              busy_pend,
  input  logic [BYTE_W-1:0] busy_code,
  input  logic [BYTE_W-1:0] head_byte,
  input  logic              head_start,
  input  logic              q_empty,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_byte,
  output logic              busy_take,
  output logic              pop
);

  logic at_bnd, send_busy;

  assign at_bnd    = q_empty || head_start;
  assign send_busy = valid_q && busy_pend && at_bnd;

  always_comb begin
    if (send_busy)     out_byte = busy_code;
    else if (!q_empty) out_byte = head_byte;
    else               out_byte = IDLE_B;
  end

  assign busy_take = send_busy && out_ready;
  assign pop       = valid_q && !send_busy && !q_empty && out_ready;

endmodule

// File: rtl/rdo_word_fmt.sv
module rdo_word_fmt
  import rdo_fmt_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   node_id,
  input  logic         ev_valid,
  output logic         ev_ready,
  input  logic [1:0]   ev_kind,
  input  logic [7:0]   ev_bunch,
  input  logic [4:0]   ev_region,
  input  logic [3:0]   ev_encoder,
  input  logic [9:0]   ev_addr,
  input  logic         ev_long,
  input  logic [6:0]   ev_hitmap,
  input  logic [3:0]   ev_flags,
  input  logic         fatal_in,
  input  logic         overrun_in,
  input  logic         busy_in,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [7:0]   out_byte
);

  logic              valid_q;
  logic              busy_pend, busy_take, pop;
  logic [BYTE_W-1:0] busy_code, head_byte;
  logic              head_start, q_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= 1'b1;
  end
  assign out_valid = valid_q;

  rdo_busy_tracker u_busy (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_in (busy_in),
    .take    (busy_take),
    .pend    (busy_pend),
    .code    (busy_code)
  );

  rdo_word_builder u_build (
    .clk        (clk),
    .rst_n      (rst_n),
    .node_id    (node_id),
    .ev_valid   (ev_valid),
    .ev_ready   (ev_ready),
    .ev_kind    (ev_kind),
    .ev_bunch   (ev_bunch),
    .ev_region  (ev_region),
    .ev_encoder (ev_encoder),
    .ev_addr    (ev_addr),
    .ev_long    (ev_long),
    .ev_hitmap  (ev_hitmap),
    .ev_flags   (ev_flags),
    .fatal_in   (fatal_in),
    .overrun_in (overrun_in),
    .pop        (pop),
    .head_byte  (head_byte),
    .head_start (head_start),
    .q_empty    (q_empty)
  );

  rdo_out_select u_sel (
    .valid_q    (valid_q),
    .busy_pend  (busy_pend),
    .busy_code  (busy_code),
    .head_byte  (head_byte),
    .head_start (head_start),
    .q_empty    (q_empty),
    .out_ready  (out_ready),
    .out_byte   (out_byte),
    .busy_take  (busy_take),
    .pop        (pop)
  );

  // R8: a busy byte is only taken where no word is half sent
  assert_busy_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_take |-> (q_empty || head_start));

  // R1: nothing is consumed from an empty queue, and never both sources at once
  assert_single_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && (busy_take || q_empty)));

  // R10: no event is accepted while bytes are still queued
  assert_ready_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_empty) |-> !ev_ready);

endmodule

// File: tb/rdo_word_fmt_tb.sv
`timescale 1ns/1ps
module rdo_word_fmt_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] node_id = 4'h5;
  logic       ev_valid = 1'b0;
  logic [1:0] ev_kind = 2'd0;
  logic [7:0] ev_bunch = '0;
  logic [4:0] ev_region = '0;
  logic [3:0] ev_encoder = '0;
  logic [9:0] ev_addr = '0;
  logic       ev_long = 1'b0;
  logic [6:0] ev_hitmap = '0;
  logic [3:0] ev_flags = '0;
  logic       fatal_in = 1'b0, overrun_in = 1'b0, busy_in = 1'b0;
  logic       out_ready = 1'b0;
  logic       ev_ready, out_valid;
  logic [7:0] out_byte;

  always #2.5 clk = ~clk;

  rdo_word_fmt u_dut (
    .clk(clk), .rst_n(rst_n), .node_id(node_id), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_bunch(ev_bunch), .ev_region(ev_region), .ev_encoder(ev_encoder),
    .ev_addr(ev_addr), .ev_long(ev_long), .ev_hitmap(ev_hitmap), .ev_flags(ev_flags),
    .fatal_in(fatal_in), .overrun_in(overrun_in), .busy_in(busy_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte)
  );

  int  checks = 0, fails = 0;
  bit  done = 1'b0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // expected byte list with word-start marks
  logic [7:0] xb [0:32767];
  bit         xs [0:32767];
  string      xt [0:32767];
  int         wr = 0, rd = 0;

  task automatic put(logic [7:0] b, bit st, string tag);
    xb[wr] = b; xs[wr] = st; xt[wr] = tag; wr++;
  endtask

  // bench-side frame state
  bit         m_open_hdr = 1'b0, m_reg_ok = 1'b0;
  logic [4:0] m_reg = '0;
  logic [7:0] m_bunch = '0;

  task automatic send(logic [1:0] k);
    @(negedge clk);
    ev_kind = k; ev_valid = 1'b1;
    #1;
    while (!ev_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    ev_valid = 1'b0;
  endtask

  task automatic do_open(logic [7:0] bc);
    m_open_hdr = 1'b1; m_reg_ok = 1'b0; m_bunch = bc;
    ev_bunch = bc;
    send(2'd0);
  endtask

  task automatic do_hit(logic [4:0] r, logic [3:0] e, logic [9:0] a, bit lng, logic [6:0] mp);
    if (m_open_hdr) begin
      put({4'hA, node_id}, 1'b1, "R3 header");
      put(m_bunch, 1'b0, "R3 header bunch");
      m_open_hdr = 1'b0;
    end
    if (!m_reg_ok || r != m_reg) put({3'b110, r}, 1'b1, "R4 region");
    m_reg_ok = 1'b1; m_reg = r;
    if (lng) begin
      put({2'b00, e, a[9:8]}, 1'b1, "R5 long b0");
      put(a[7:0], 1'b0, "R5 long b1");
      put({1'b0, mp}, 1'b0, "R5 long map");
    end else begin
      put({2'b01, e, a[9:8]}, 1'b1, "R5 short b0");
      put(a[7:0], 1'b0, "R5 short b1");
    end
    ev_region = r; ev_encoder = e; ev_addr = a; ev_long = lng; ev_hitmap = mp;
    send(2'd1);
  endtask

  task automatic do_close(logic [3:0] f);
    if (m_open_hdr) begin
      put({4'hE, node_id}, 1'b1, "R2 empty");
      put(m_bunch, 1'b0, "R2 empty bunch");
    end else if (fatal_in) put(8'hBE, 1'b1, "R7 fatal trailer");
    else if (overrun_in)   put(8'hBC, 1'b1, "R7 overrun trailer");
    else                   put({4'hB, f}, 1'b1, "R6 trailer");
    m_open_hdr = 1'b0; m_reg_ok = 1'b0;
    ev_flags = f;
    send(2'd2);
  endtask

  // output parser
  bit mid = 1'b0, last_busy = 1'b0, coll_en = 1'b0, busy_rand = 1'b0;
  int rdy_mode = 0;

  task automatic take_byte(logic [7:0] b);
    if (!mid) begin
      if (b == 8'hFF) return;
      if (b == 8'hF0 || b == 8'hF1) begin
        chk(b[0] != last_busy, "R8 busy alternation", b, {7'h78, ~last_busy});
        last_busy = b[0];
        return;
      end
      if (rd >= wr) begin
        chk(1'b0, "R1 unexpected byte", b, 8'hFF);
        return;
      end
      chk(xs[rd] && b == xb[rd], xt[rd], b, xb[rd]);
    end else begin
      chk(!xs[rd] && b == xb[rd], {xt[rd], " (R8 split)"}, b, xb[rd]);
    end
    rd++;
    mid = (rd < wr) && !xs[rd];
  endtask

  always @(negedge clk) begin
    if (coll_en) begin
      case (rdy_mode)
        0:       out_ready = (($urandom % 4) != 0);
        1:       out_ready = 1'b1;
        default: out_ready = 1'b0;
      endcase
      #1;
      if (out_ready && out_valid) take_byte(out_byte);
    end
  end

  always @(negedge clk) begin
    if (busy_rand && ($urandom % 23) == 0) busy_in = ~busy_in;
  end

  task automatic drain();
    while (rd != wr) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      report();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(out_valid == 1'b1, "R1 valid after reset", out_valid, 1);
    chk(out_byte == 8'hFF, "R1 idle after reset", out_byte, 8'hFF);
    chk(ev_ready == 1'b1, "R10 ready after reset", ev_ready, 1);
    coll_en = 1'b1; rdy_mode = 1;

    // R8: busy word latency on an idle link
    @(negedge clk); busy_in = 1'b1;
    @(negedge clk); #1;
    chk(out_byte == 8'hF1, "R8 busy on", out_byte, 8'hF1);
    @(negedge clk); #1;
    chk(out_byte == 8'hFF, "R1 idle after busy word", out_byte, 8'hFF);
    busy_in = 1'b0;
    @(negedge clk); #1;
    chk(out_byte == 8'hF0, "R8 busy off", out_byte, 8'hF0);

    // R2: frame with no hits
    do_open(8'h3C); do_close(4'h7);
    drain();

    // R9: busy report overtakes a queued header
    rdy_mode = 2;
    do_open(8'h91);
    do_hit(5'd3, 4'h2, 10'h155, 1'b0, 7'h00);
    @(negedge clk); busy_in = 1'b1;
    @(negedge clk); #1;
    chk(out_byte == 8'hF1, "R9 busy before header", out_byte, 8'hF1);
    chk(ev_ready == 1'b0, "R10 held while queued", ev_ready, 0);
    rdy_mode = 0;
    do_hit(5'd3, 4'h7, 10'h3FF, 1'b1, 7'b0010110);  // R4 same region, R5 long
    do_hit(5'd9, 4'h0, 10'h006, 1'b1, 7'h41);
    do_close(4'b1010);
    drain();

    // R10: kind 3 is ignored and keeps the frame state
    rdy_mode = 1;
    do_open(8'h44);
    ev_bunch = 8'h00; ev_region = 5'd31;
    send(2'd3);
    repeat (3) @(negedge clk);
    #1;
    chk(out_byte == 8'hFF, "R10 ignored kind output", out_byte, 8'hFF);
    chk(ev_ready == 1'b1, "R10 ignored kind queue", ev_ready, 1);
    do_close(4'h1);  // still an empty frame with bunch 44
    drain();

    // R7: override priorities
    fatal_in = 1'b1; overrun_in = 1'b1;
    do_open(8'h10); do_hit(5'd0, 4'h1, 10'h001, 1'b0, '0); do_close(4'b0001);
    fatal_in = 1'b0;
    do_open(8'h11); do_hit(5'd1, 4'h1, 10'h002, 1'b0, '0); do_close(4'b0011);
    overrun_in = 1'b0;
    do_open(8'h12); do_hit(5'd2, 4'h1, 10'h003, 1'b0, '0); do_close(4'b0101);
    drain();

    // sweep: busy toggles and stalls against random frames
    node_id = 4'h9; busy_rand = 1'b1; rdy_mode = 0;
    for (int f = 0; f < 400; f++) begin
      int nh;
      logic [4:0] r;
      nh = $urandom % 5;
      r  = 5'($urandom % 4);
      do_open(8'($urandom));
      for (int h = 0; h < nh; h++) begin
        int step;
        step = $urandom % 3;
        if (int'(r) + step <= 31) r = r + 5'(step);
        do_hit(r, 4'($urandom), 10'($urandom), 1'($urandom), 7'($urandom));
      end
      fatal_in   = (($urandom % 8) == 0);
      overrun_in = (($urandom % 6) == 0);
      do_close(4'($urandom));
    end
    fatal_in = 1'b0; overrun_in = 1'b0;
    busy_rand = 1'b0; rdy_mode = 1;
    drain();
    repeat (6) @(negedge clk);
    chk(rd == wr, "R1 all words delivered", rd, wr);
    chk(last_busy == busy_in, "R8 final busy report", last_busy, busy_in);
    report();
  end

endmodule